// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR2 memory interface and owns the command and address pins from reset until the memory is ready for use. Once a power-stable indication arrives it works through a fixed series of steps. It holds CKE low for the settling interval, raises CKE and waits again, then issues a precharge-all. Four mode-register loads follow, selected by bank address: the two upper extended registers, then the DLL-enable load, then the DLL-reset load. A second precharge-all, a burst of refreshes and one dummy write complete the sequence, and init-done is then raised.

All wait lengths are whole clock cycles, derived from nanosecond parameters and a clock-period parameter by rounding up. Until init-done rises, every user command, bank address, address and termination request is blocked. After that the user inputs drive the pins directly.

The command bus is packed as `cmd_o = {cs_n, ras_n, cas_n, we_n}`.

Top module: `ddr2_init_seq`

## Requirements
- R1: While rst_ni is low, and afterwards until pwr_stable_i is sampled high, cke_o=0, odt_o=0, cmd_o=NOP (4'b0111), ba_o=0, addr_o=0 and init_done_o=0.
- R2: If pwr_stable_i is first sampled high at rising edge k, cke_o goes high after edge k+ceil(T_STABLE_NS*1000/CLK_PERIOD_PS), with a minimum of one cycle. Before that, cmd_o stays NOP.
- R3: A precharge-all (cmd_o=4'b0010, addr_o[10]=1, ba_o=0) is issued ceil(T_CKE_NS/period) cycles after cke_o rises. No other command is issued between the rise and the precharge-all.
- R4: After the precharge-all, four mode loads are issued with cmd_o=4'b0000. The first comes ceil(T_RP_NS/period) cycles after the precharge-all, and the others follow MRD_CYC cycles apart. In order they are: ba_o=2 with addr_o=0; ba_o=3 with addr_o=0; ba_o=1 with addr_o=0 (A0=0 enables the DLL, and bits 7 to 9 are zero); ba_o=0 with addr_o=13'h100 (A8=1 resets the DLL).
- R5: Once cke_o is high it stays high until reset.
- R6: MRD_CYC cycles after the DLL-reset load, a second precharge-all is issued. N_REF refreshes (cmd_o=4'b0001) follow, the first ceil(T_RP_NS/period) cycles after the precharge-all and the rest ceil(T_RFC_NS/period) cycles apart.
- R7: One dummy write (cmd_o=4'b0100, ba_o=0, addr_o=0) is issued in the later of two cycles. One is DLL_LOCK_CYC cycles after the DLL-reset load. The other is ceil(T_RFC_NS/period)+1 cycles after the last refresh.
- R8: init_done_o rises in the cycle after the dummy write and stays high until reset.
- R9: While init_done_o is low, user_cmd_i, user_ba_i, user_addr_i and user_odt_i have no effect on any output, and odt_o is 0.
- R10: While init_done_o is high, cmd_o, ba_o, addr_o and odt_o equal user_cmd_i, user_ba_i, user_addr_i and user_odt_i in the same cycle, and cke_o is 1.
- R11: Once the sequence has left the idle state, pwr_stable_i is ignored. Dropping it does not change the sequence or its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_stable_i | input | 1 | Supplies and clock are stable |
| user_cmd_i | input | 4 | User command {cs_n, ras_n, cas_n, we_n} |
| user_ba_i | input | 2 | User bank address |
| user_addr_i | input | ADDR_W | User address |
| user_odt_i | input | 1 | User termination request |
| cke_o | output | 1 | Clock enable to memory |
| odt_o | output | 1 | On-die termination to memory |
| cmd_o | output | 4 | Command pins {cs_n, ras_n, cas_n, we_n} |
| ba_o | output | 2 | Bank address pins |
| addr_o | output | ADDR_W | Address pins |
| init_done_o | output | 1 | Initialization complete |

## Verification
Each sequence output is a function of the step register alone. A step boundary sampled at a rising edge therefore shows up on the pins in the cycle that begins at that same edge. The bench's reference model notes the edge at which pwr_stable_i is first taken. From that edge it computes the exact cycle of every command, the CKE rise, the write and the done flag, using the rounded-up cycle counts given in the requirements.

The user path is combinational once init-done is high, so changes on the user inputs are due on the pins in the same cycle. User inputs are moved one nanosecond after each rising edge, and every output is compared against the model at each falling edge. Because the comparison runs on every clock, an early or late command fails as surely as a wrong one.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;
  typedef logic [3:0] cmd_t;  // {cs_n, ras_n, cas_n, we_n}

  localparam cmd_t CMD_NOP = 4'b0111;
  localparam cmd_t CMD_PRE = 4'b0010;
  localparam cmd_t CMD_MRS = 4'b0000;
  localparam cmd_t CMD_REF = 4'b0001;
  localparam cmd_t CMD_WR  = 4'b0100;

  // fixed step indices; refresh, lock, write and done steps follow ST_REF0
  localparam int ST_IDLE   = 0;
  localparam int ST_STABLE = 1;
  localparam int ST_CKE    = 2;
  localparam int ST_PRE1   = 3;
  localparam int ST_EMR2   = 4;
  localparam int ST_EMR3   = 5;
  localparam int ST_EMR1   = 6;
  localparam int ST_MRRST  = 7;
  localparam int ST_PRE2   = 8;
  localparam int ST_REF0   = 9;

  function automatic int ns_to_cyc(int ns, int period_ps);
    int c;
    c = (ns * 1000 + period_ps - 1) / period_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ddr2_init_timer.sv
module ddr2_init_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ddr2_init_dur_rom.sv
module ddr2_init_dur_rom import ddr2_init_pkg::*; #(
  parameter int STW        = 4,
  parameter int CW         = 8,
  parameter int N_REF      = 2,
  parameter int STABLE_CYC = 1,
  parameter int CKE_CYC    = 1,
  parameter int RP_CYC     = 1,
  parameter int RFC_CYC    = 1,
  parameter int MRD_CYC    = 1
) (
  input  logic [STW-1:0] step_i,
  output logic [CW-1:0]  dur_m1_o
);
  always_comb begin
    dur_m1_o = '0;
    if (int'(step_i) == ST_STABLE)                        dur_m1_o = CW'(STABLE_CYC - 1);
    else if (int'(step_i) == ST_CKE)                      dur_m1_o = CW'(CKE_CYC - 1);
    else if (int'(step_i) == ST_PRE1 ||
             int'(step_i) == ST_PRE2)                     dur_m1_o = CW'(RP_CYC - 1);
    else if (int'(step_i) >= ST_EMR2 &&
             int'(step_i) <= ST_MRRST)                    dur_m1_o = CW'(MRD_CYC - 1);
    else if (int'(step_i) >= ST_REF0 &&
             int'(step_i) <  ST_REF0 + N_REF)             dur_m1_o = CW'(RFC_CYC - 1);
  end
endmodule

// File: rtl/ddr2_init_cmd_rom.sv
module ddr2_init_cmd_rom import ddr2_init_pkg::*; #(
  parameter int STW    = 4,
  parameter int ADDR_W = 13,
  parameter int N_REF  = 2
) (
  input  logic [STW-1:0]    step_i,
  output cmd_t              cmd_o,
  output logic [1:0]        ba_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int ST_WR = ST_REF0 + N_REF + 1;

  always_comb begin
    cmd_o  = CMD_NOP;
    ba_o   = 2'd0;
    addr_o = '0;
    if (int'(step_i) == ST_PRE1 || int'(step_i) == ST_PRE2) begin
      cmd_o      = CMD_PRE;
      addr_o[10] = 1'b1;  // all banks
    end else if (int'(step_i) == ST_EMR2) begin
      cmd_o = CMD_MRS;
      ba_o  = 2'd2;
    end else if (int'(step_i) == ST_EMR3) begin
      cmd_o = CMD_MRS;
      ba_o  = 2'd3;
    end else if (int'(step_i) == ST_EMR1) begin
      cmd_o = CMD_MRS;    // A0=0: DLL on, E7..E9 zero
      ba_o  = 2'd1;
    end else if (int'(step_i) == ST_MRRST) begin
      cmd_o     = CMD_MRS;
      addr_o[8] = 1'b1;   // DLL reset
    end else if (int'(step_i) >= ST_REF0 && int'(step_i) < ST_REF0 + N_REF) begin
      cmd_o = CMD_REF;
    end else if (int'(step_i) == ST_WR) begin
      cmd_o = CMD_WR;
    end
  end
endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq import ddr2_init_pkg::*; #(
  parameter int CLK_PERIOD_PS = 20000,
  parameter int T_STABLE_NS   = 200000,
  parameter int T_CKE_NS      = 400,
  parameter int T_RP_NS       = 15,
  parameter int T_RFC_NS      = 128,
  parameter int MRD_CYC       = 2,
  parameter int DLL_LOCK_CYC  = 200,
  parameter int N_REF         = 2,
  parameter int ADDR_W        = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_stable_i,
  input  logic [3:0]        user_cmd_i,
  input  logic [1:0]        user_ba_i,
  input  logic [ADDR_W-1:0] user_addr_i,
  input  logic              user_odt_i,
  output logic              cke_o,
  output logic              odt_o,
  output logic [3:0]        cmd_o,
  output logic [1:0]        ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              init_done_o
);
  localparam int STABLE_CYC = ns_to_cyc(T_STABLE_NS, CLK_PERIOD_PS);
  localparam int CKE_CYC    = ns_to_cyc(T_CKE_NS, CLK_PERIOD_PS);
  localparam int RP_CYC     = ns_to_cyc(T_RP_NS, CLK_PERIOD_PS);
  localparam int RFC_CYC    = ns_to_cyc(T_RFC_NS, CLK_PERIOD_PS);
  localparam int MAX_DUR    = max2(max2(max2(STABLE_CYC, CKE_CYC), max2(RP_CYC, RFC_CYC)),
                                   max2(MRD_CYC, DLL_LOCK_CYC));
  localparam int CW         = $clog2(MAX_DUR + 1);
  localparam int ST_LOCK    = ST_REF0 + N_REF;
  localparam int ST_WR      = ST_LOCK + 1;
  localparam int ST_DONE    = ST_WR + 1;
  localparam int STW        = $clog2(ST_DONE + 1);

  logic [STW-1:0]    st_q, st_nxt;
  logic              first_q, adv, step_zero, dll_zero, dll_load;
  logic [CW-1:0]     dur_m1;
  cmd_t              rom_cmd;
  logic [1:0]        rom_ba;
  logic [ADDR_W-1:0] rom_addr;

  always_comb begin
    st_nxt = st_q + 1'b1;
    if (int'(st_q) == ST_IDLE)      adv = pwr_stable_i;
    else if (int'(st_q) == ST_LOCK) adv = dll_zero;
    else if (int'(st_q) == ST_DONE) adv = 1'b0;
    else                            adv = step_zero;
  end

  assign dll_load = adv && (int'(st_nxt) == ST_MRRST);

  ddr2_init_dur_rom #(
    .STW(STW), .CW(CW), .N_REF(N_REF), .STABLE_CYC(STABLE_CYC), .CKE_CYC(CKE_CYC),
    .RP_CYC(RP_CYC), .RFC_CYC(RFC_CYC), .MRD_CYC(MRD_CYC)
  ) u_dur (
    .step_i(st_nxt), .dur_m1_o(dur_m1)
  );

  ddr2_init_cmd_rom #(.STW(STW), .ADDR_W(ADDR_W), .N_REF(N_REF)) u_cmd (
    .step_i(st_q), .cmd_o(rom_cmd), .ba_o(rom_ba), .addr_o(rom_addr)
  );

  ddr2_init_timer #(.CW(CW)) u_step_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(adv), .load_val_i(dur_m1), .zero_o(step_zero)
  );

  // DLL lock window runs in parallel with the precharge and refresh steps
  ddr2_init_timer #(.CW(CW)) u_dll_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(dll_load),
    .load_val_i(CW'(DLL_LOCK_CYC - 1)), .zero_o(dll_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= '0;
      first_q <= 1'b0;
    end else begin
      first_q <= adv;
      if (adv) st_q <= st_nxt;
    end
  end

  assign init_done_o = (int'(st_q) == ST_DONE);
  assign cke_o       = (int'(st_q) >= ST_CKE);
  assign odt_o       = init_done_o & user_odt_i;
  assign cmd_o       = init_done_o ? user_cmd_i  : (first_q ? rom_cmd  : CMD_NOP);
  assign ba_o        = init_done_o ? user_ba_i   : (first_q ? rom_ba   : 2'd0);
  assign addr_o      = init_done_o ? user_addr_i : (first_q ? rom_addr : '0);

  // cycles since the DLL-reset load, saturating at the lock window
  int lock_age;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lock_age <= 0;
    else if (!init_done_o && cmd_o == CMD_MRS && ba_o == 2'd0) lock_age <= 1;
    else if (lock_age != 0 && lock_age < DLL_LOCK_CYC) lock_age <= lock_age + 1;
  end

  p_dll_lock_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_done_o && cmd_o == CMD_WR) |-> (lock_age >= DLL_LOCK_CYC));
  p_cke_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cke_o) |-> cke_o);
  p_done_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);
  p_done_after_wr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(init_done_o) |-> ($past(cmd_o) == CMD_WR));
  p_odt_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_done_o |-> !odt_o);
  p_pre_all_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_done_o && cmd_o == CMD_PRE) |-> addr_o[10]);
  p_mrs_cke_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_done_o && cmd_o == CMD_MRS) |-> cke_o);
endmodule

// File: tb/tb_ddr2_init_seq.sv
module tb_ddr2_init_seq;
  localparam int PER_PS = 20000;
  localparam int AW     = 13;
  localparam int MRD    = 2;
  localparam int DLL    = 200;
  localparam int NREF   = 2;

  function automatic int cyc_of(int ns);
    int c;
    c = (ns * 1000 + PER_PS - 1) / PER_PS;
    if (c < 1) c = 1;
    return c;
  endfunction

  logic clk, rst_n, pwr;
  logic [3:0] u_cmd;
  logic [1:0] u_ba;
  logic [AW-1:0] u_addr;
  logic u_odt;
  logic cke, odt, done;
  logic [3:0] cmd;
  logic [1:0] ba;
  logic [AW-1:0] addr;

  ddr2_init_seq #(
    .CLK_PERIOD_PS(PER_PS), .T_STABLE_NS(200000), .T_CKE_NS(400), .T_RP_NS(15),
    .T_RFC_NS(128), .MRD_CYC(MRD), .DLL_LOCK_CYC(DLL), .N_REF(NREF), .ADDR_W(AW)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .pwr_stable_i(pwr), .user_cmd_i(u_cmd), .user_ba_i(u_ba),
    .user_addr_i(u_addr), .user_odt_i(u_odt), .cke_o(cke), .odt_o(odt), .cmd_o(cmd),
    .ba_o(ba), .addr_o(addr), .init_done_o(done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  int cyc = 0, tp = -1, checks = 0, errors = 0;
  int s_c, p1, e2, e3, e1, m_c, p2, lk, wr;
  logic prev_cke = 1'b0;
  logic e_cke, e_odt, e_done;
  logic [3:0] e_cmd;
  logic [1:0] e_ba;
  logic [AW-1:0] e_addr;
  string tag;

  initial begin
    s_c = cyc_of(200000);
    p1  = s_c + cyc_of(400);
    e2  = p1 + cyc_of(15);
    e3  = e2 + MRD;
    e1  = e3 + MRD;
    m_c = e1 + MRD;
    p2  = m_c + MRD;
    lk  = p2 + cyc_of(15) + NREF * cyc_of(128);
    wr  = (lk + 1 > m_c + DLL) ? lk + 1 : m_c + DLL;
  end

  // model: edge index at which the power indication is taken
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) tp = -1;
    else if (tp < 0 && pwr) tp = cyc;
  end

  // hostile user stimulus, moved just after each rising edge
  always @(posedge clk) begin
    #1;
    u_cmd  = 4'(cyc * 5 + 1);
    u_ba   = 2'(cyc);
    u_addr = AW'(cyc * 37);
    u_odt  = cyc[0];
  end

  task automatic model();
    int rel;
    e_cke = 1'b0; e_odt = 1'b0; e_done = 1'b0;
    e_cmd = 4'b0111; e_ba = 2'd0; e_addr = '0;
    if (!rst_n || tp < 0) begin
      tag = rst_n ? "R1" : "R1 R8";
      return;
    end
    rel = cyc - tp;
    if (rel > wr) begin
      e_cke = 1'b1; e_done = 1'b1;
      e_cmd = u_cmd; e_ba = u_ba; e_addr = u_addr; e_odt = u_odt;
      tag = (rel == wr + 1) ? "R8" : "R8 R10";
      return;
    end
    e_cke = (rel >= s_c);
    if (rel < s_c) tag = "R2";
    else if (rel <= p1) tag = "R3";
    else if (rel < p2) tag = "R4";
    else if (rel < lk) tag = "R6";
    else tag = "R7";
    if (rel == p1 || rel == p2) begin e_cmd = 4'b0010; e_addr = AW'(1 << 10); end
    else if (rel == e2) begin e_cmd = 4'b0000; e_ba = 2'd2; end
    else if (rel == e3) begin e_cmd = 4'b0000; e_ba = 2'd3; end
    else if (rel == e1) begin e_cmd = 4'b0000; e_ba = 2'd1; end
    else if (rel == m_c) begin e_cmd = 4'b0000; e_addr = AW'(13'h100); end
    else if (rel == wr) e_cmd = 4'b0100;
    else begin
      for (int i = 0; i < NREF; i++)
        if (rel == p2 + cyc_of(15) + i * cyc_of(128)) e_cmd = 4'b0001;
    end
    tag = {tag, " R9"};
    if (!pwr) tag = {tag, " R11"};
  endtask

  always @(negedge clk) begin
    model();
    checks++;
    if ({cke, odt, cmd, ba, addr, done} !== {e_cke, e_odt, e_cmd, e_ba, e_addr, e_done}) begin
      errors++;
      $display("FAIL %s cyc %0d actual cke=%b odt=%b cmd=%b ba=%0d addr=%h done=%b expected cke=%b odt=%b cmd=%b ba=%0d addr=%h done=%b",
               tag, cyc, cke, odt, cmd, ba, addr, done, e_cke, e_odt, e_cmd, e_ba, e_addr, e_done);
    end
    if (rst_n && prev_cke) begin
      checks++;
      if (cke !== 1'b1) begin
        errors++;
        $display("FAIL R5 cyc %0d actual cke=%b expected 1", cyc, cke);
      end
    end
    prev_cke = rst_n ? cke : 1'b0;
  end

  always @(posedge clk) begin
    if (cyc > 60000) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog: actual init_done_o=%b expected 1", done);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b1; pwr = 1'b0;
    #1 rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (6) @(posedge clk);          // R1 idle without power indication
    #1 pwr = 1'b1;
    repeat (60) @(posedge clk);
    #1 pwr = 1'b0;                      // R11 drop after leaving idle
    while (!done) @(posedge clk);
    repeat (30) @(posedge clk);         // R10 pass-through
    #1 rst_n = 1'b0;                    // R8 cleared only by reset
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    #1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule